// File: doc/BRIEF.md
# Three-Valued Output Resolution Merger

This block merges several requests aimed at one Boolean control output into a single resolved value. Each request is three-valued: it either demands a 1, demands a 0, or leaves the output free. The merge is not a plain OR. A demand for 1 wins over everything else. A demand for 0 wins only when no source demands 1. When every source leaves the output free, the result falls back to a constant fixed at build time.

A separate flag reports a contradiction: in the same cycle, one source demands 1 while another demands 0. Each input can be given an inversion at build time. An inversion swaps a demand for 1 with a demand for 0 and passes a free request through untouched. This lets a source that drives the complement of the output share the merger.

The block is purely combinational. The number of inputs is a parameter, and it equals the number of sources that request this output.

Top module: `rsv_merge`

## Requirements
- R1: Request encoding: bit i of `reqValid` and bit i of `reqValue` form request i. `reqValid`=0 means "free" (no constraint). `reqValid`=1 means "demand `reqValue`" (after the inversion of R6).
- R2: If any effective request demands 1, `resolved` is 1 in the same cycle.
- R3: If at least one effective request demands 0 and none demands 1, `resolved` is 0.
- R4: If every request is free, `resolved` equals the parameter `DEFAULT_VAL`.
- R5: `conflict` is 1 exactly when one effective request demands 1 and another demands 0 in the same cycle. In that case `resolved` is 1.
- R6: When bit i of parameter `INVERT_MASK` is 1, a valid request i has its demanded value inverted before the merge.
- R7: A free request has no effect on `resolved` or `conflict`, whatever its `reqValue` bit holds. This also applies when the input is inverted.
- R8: The merger has `N_REQ` request inputs, one per requesting source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reqValid | input | N_REQ | Per-source flag: 1 = constrains the output |
| reqValue | input | N_REQ | Per-source demanded value, used when valid |
| resolved | output | 1 | Merged Boolean output |
| conflict | output | 1 | High while contradictory demands are present |

## Verification
The checker assumes that all request bits are fully driven, with no X or Z. It evaluates after the combinational logic has settled, so it expects inputs to change as a group rather than bit by bit across delta cycles. The bench meets both assumptions: it drives `reqValid` and `reqValue` together on the falling clock edge and samples on the rising edge. It also sweeps every one of the 2^(2·N_REQ) input combinations once, so every mix of free, 0 and 1 demands is covered, including on the inverted input.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  // Strobes from the decode (control) side to the output datapath.
  typedef struct packed {
    logic anyHigh;   // some effective request demands 1
    logic anyLow;    // some effective request demands 0
    logic allFree;   // no request constrains the output
  } rsv_strobe_t;
endpackage

// File: rtl/rsv_datapath.sv
module rsv_datapath #(
  parameter int unsigned N_REQ = 4,
  parameter logic [N_REQ-1:0] INVERT_MASK = '0,
  parameter bit DEFAULT_VAL = 1'b0
) (
  input  logic [N_REQ-1:0]   reqValid,
  input  logic [N_REQ-1:0]   reqValue,
  input  rsv_pkg::rsv_strobe_t strobe,
  output logic [N_REQ-1:0]   effValid,
  output logic [N_REQ-1:0]   effValue,
  output logic               resolved,
  output logic               conflict
);
  // Polarity stage. An inverted lane flips only the demanded value;
  // the valid bit passes through, so a free request stays free.
  for (genvar i = 0; i < N_REQ; i++) begin : g_lane
    if (INVERT_MASK[i]) begin : g_inv
      assign effValue[i] = ~reqValue[i];
    end else begin : g_pass
      assign effValue[i] = reqValue[i];
    end
    assign effValid[i] = reqValid[i];
  end

  // Output select: a 1 demand dominates, then a 0 demand, then the default.
  always_comb begin
    if (strobe.anyHigh)     resolved = 1'b1;
    else if (strobe.anyLow) resolved = 1'b0;
    else                    resolved = DEFAULT_VAL;
    conflict = strobe.anyHigh & strobe.anyLow;
  end
endmodule

// File: rtl/rsv_ctrl.sv
module rsv_ctrl #(
  parameter int unsigned N_REQ = 4
) (
  input  logic [N_REQ-1:0]     effValid,
  input  logic [N_REQ-1:0]     effValue,
  output rsv_pkg::rsv_strobe_t strobe
);
  logic [N_REQ-1:0] highMask;
  logic [N_REQ-1:0] lowMask;

  assign highMask       = effValid & effValue;
  assign lowMask        = effValid & ~effValue;
  assign strobe.anyHigh = |highMask;
  assign strobe.anyLow  = |lowMask;
  assign strobe.allFree = ~|effValid;
endmodule

// File: rtl/rsv_merge.sv
module rsv_merge #(
  parameter int unsigned N_REQ = 4,
  parameter logic [N_REQ-1:0] INVERT_MASK = '0,
  parameter bit DEFAULT_VAL = 1'b0
) (
  input  logic [N_REQ-1:0] reqValid,
  input  logic [N_REQ-1:0] reqValue,
  output logic             resolved,
  output logic             conflict
);
  rsv_pkg::rsv_strobe_t strobe;
  logic [N_REQ-1:0] effValid;
  logic [N_REQ-1:0] effValue;

  rsv_datapath #(
    .N_REQ(N_REQ), .INVERT_MASK(INVERT_MASK), .DEFAULT_VAL(DEFAULT_VAL)
  ) u_dp (
    .reqValid(reqValid), .reqValue(reqValue), .strobe(strobe),
    .effValid(effValid), .effValue(effValue),
    .resolved(resolved), .conflict(conflict)
  );

  rsv_ctrl #(.N_REQ(N_REQ)) u_ctrl (
    .effValid(effValid), .effValue(effValue), .strobe(strobe)
  );
endmodule

// File: rtl/rsv_merge_chk.sv
module rsv_merge_chk #(
  parameter int unsigned N_REQ = 4,
  parameter logic [N_REQ-1:0] INVERT_MASK = '0,
  parameter bit DEFAULT_VAL = 1'b0
) (
  input logic [N_REQ-1:0] reqValid,
  input logic [N_REQ-1:0] reqValue,
  input logic             resolved,
  input logic             conflict
);
  // Value demanded by the lowest valid lane, port-level view.
  function automatic logic firstDemand(input logic [N_REQ-1:0] v,
                                       input logic [N_REQ-1:0] d);
    logic r;
    r = 1'b0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (v[i]) r = d[i] ^ INVERT_MASK[i];
    end
    return r;
  endfunction

  always_comb begin
    AST_CONFLICT_FORCES_HIGH: assert (!conflict || resolved) else $error("conflict without high output"); // R5
    AST_CONFLICT_NEEDS_TWO: assert (!conflict || ($countones(reqValid) >= 2)) else $error("conflict with <2 valid"); // R5
    AST_FREE_GIVES_DEFAULT: assert ((reqValid != '0) || (resolved == DEFAULT_VAL && !conflict)) else $error("free case wrong"); // R4
    AST_SINGLE_FOLLOWS: assert (($countones(reqValid) != 1) || (resolved == firstDemand(reqValid, reqValue) && !conflict)) else $error("single request not followed"); // R6
  end
endmodule

bind rsv_merge rsv_merge_chk #(
  .N_REQ(N_REQ), .INVERT_MASK(INVERT_MASK), .DEFAULT_VAL(DEFAULT_VAL)
) u_chk (
  .reqValid(reqValid), .reqValue(reqValue),
  .resolved(resolved), .conflict(conflict)
);

// File: tb/rsv_merge_tb.sv
module rsv_merge_tb;
  localparam int unsigned N = 4;
  localparam logic [N-1:0] MASK = 4'b0100;
  localparam bit DEF = 1'b0;

  typedef struct {
    logic  expOut;
    logic  expConf;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic [N-1:0] reqValid = '0;
  logic [N-1:0] reqValue = '0;
  logic resolved, conflict;
  int checks = 0;
  int errors = 0;
  item_t sbq[$];

  always #4 clk = ~clk;  // 125 MHz

  rsv_merge #(.N_REQ(N), .INVERT_MASK(MASK), .DEFAULT_VAL(DEF)) u_dut (
    .reqValid(reqValid), .reqValue(reqValue),
    .resolved(resolved), .conflict(conflict)
  );

  // Reference model built from the requirements.
  task automatic drive(input logic [N-1:0] v, input logic [N-1:0] d, input string tag);
    item_t it;
    logic hi, lo;
    hi = 1'b0; lo = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (v[i]) begin
        if (d[i] ^ MASK[i]) hi = 1'b1; else lo = 1'b1;
      end
    end
    it.expOut  = hi ? 1'b1 : (lo ? 1'b0 : DEF);
    it.expConf = hi & lo;
    it.tag = tag;
    @(negedge clk);
    reqValid = v;
    reqValue = d;
    sbq.push_back(it);
  endtask

  // Monitor: compares on the rising edge, half a period after driving.
  always @(posedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks += 2;
      if (resolved !== it.expOut) begin
        errors++;
        $display("FAIL %s resolved actual=%b expected=%b (v=%b d=%b)", it.tag, resolved, it.expOut, reqValid, reqValue);
      end
      if (conflict !== it.expConf) begin
        errors++;
        $display("FAIL %s conflict actual=%b expected=%b (v=%b d=%b)", it.tag, conflict, it.expConf, reqValid, reqValue);
      end
    end
  end

  initial begin
    fork
      begin
        drive(4'b0000, 4'b0000, "R4 idle all free");
        drive(4'b0000, 4'b1111, "R7 free lanes ignore value");
        drive(4'b0001, 4'b0001, "R2 single high");
        drive(4'b0001, 4'b0000, "R3 single low");
        drive(4'b0011, 4'b0000, "R3 two lows");
        drive(4'b1001, 4'b1000, "R5 high vs low conflict");
        drive(4'b0100, 4'b0000, "R6 inverted lane 0 demands 1");
        drive(4'b0100, 4'b0100, "R6 inverted lane 1 demands 0");
        drive(4'b0101, 4'b0100, "R6 r5_ inverted low plus low");
        drive(4'b0101, 4'b0000, "R5 inverted high vs low conflict");
        drive(4'b1010, 4'b0101, "R7 free bits set, valid lows");
        drive(4'b1000, 4'b0111, "R8 top lane only high? no, low");
        drive(4'b1111, 4'b1011, "R2 all valid high incl inverted");
        for (int k = 0; k < (1 << (2 * N)); k++) begin
          drive(k[N-1:0], k[2*N-1:N], "R1 sweep");
        end
        @(negedge clk);
        @(negedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule